// File: doc/BRIEF.md
# Grouped Level Interrupt Combiner

This block gathers a wide vector of level-sensitive interrupt sources into one output line per group of eight sources. Source `n` sits in group `n/8` at bit `n%8`. Each source carries an enable bit. A group line is high while at least one of its sources is both high and enabled. The group lines feed a downstream interrupt controller, which sees one line per group instead of one line per source.

Software controls the enables through a small synchronous register port that uses word addresses. Four groups share each 32-bit word, one byte lane each. The enables change only through a write-ones-to-set word and a write-ones-to-clear word, so two agents can each change their own sources without a read-modify-write. Two status words per quad show the raw source levels and the enabled levels. Two summary words give one bit per group line. A parameter can limit how many groups respond to their inputs; groups above that limit stay silent.

Top module: `irq_group_combiner`

## Requirements
- R1: Source bit `n` of `srcIn` is pending in group `n/8` at bit `n%8` while the input is high, and stops being pending once it goes low. Nothing latches it. The pending byte of group `4q+k` shows up in byte lane `k` (bits `8k+7:8k`) of the raw status word at word address `4q+2`.
- R2: Bit `g` of `grpIrq` is high exactly when group `g` has at least one source that is both pending and enabled. It follows a change on `srcIn` one clock later.
- R3: A write to word address `4q` (enable-set) sets the enable bit of every source whose bit is 1 in byte lane `k` of the data, for group `4q+k`. Bits written as 0 leave their enables as they were.
- R4: A write to word address `4q+1` (enable-clear) clears the enable bit of every source whose bit is 1 in byte lane `k`, for group `4q+k`. Bits written as 0 leave their enables as they were.
- R5: A read of word address `4q+2` returns the pending bytes of groups `4q..4q+3` before enabling is applied.
- R6: A read of word address `4q+3` returns, per byte lane, the pending byte ANDed with the enable byte.
- R7: Word addresses 64 and 65 are the summary words. Bit `b` of word `64+s` equals the line of group `32s+b`. Bits for groups that do not exist read 0.
- R8: While `rstN` is low, all enables, pending bits, group lines, `rdata` and `wrErr` are 0.
- R9: The following writes are illegal: to a status word (`4q+2`, `4q+3`), to any word address 64 or above, and to a quad beyond the last group. An illegal write raises `wrErr` for exactly the next cycle and changes no enable.
- R10: `rdata` carries the read result one cycle after `rdEn`. Reads of enable-set words, enable-clear words and unmapped addresses return 0.
- R11: Groups at or above `ACTIVE_GROUPS` ignore their inputs. Their pending bytes read 0 and their lines stay low, whatever their enables.
- R12: A group line follows an enable-set or enable-clear write one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcIn | input | NUM_GROUPS*8 | Level-sensitive interrupt sources |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 7 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rdEn` |
| wrErr | output | 1 | One-cycle pulse after an illegal write |
| grpIrq | output | NUM_GROUPS | One interrupt line per group |

## Verification
The bench builds the block with `NUM_GROUPS=8` and `ACTIVE_GROUPS=6`, which makes two quads and 64 sources. This shape reaches, in a short run, the byte lanes of a second quad, two ignored groups with all their enables set, and a summary word whose upper half has no groups behind it. It also reaches an unused quad address below 64, which must count as an illegal write. A reference model in the bench tracks the enables and source levels. It predicts every read word, every group line and every error pulse, cycle by cycle, including across a reset in the middle of the run.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;
  localparam int LANE_W   = 8;   // sources per group, one byte lane
  localparam int LANES    = 4;   // groups per register word
  localparam int WORD_W   = LANE_W * LANES;
  localparam int REG_AW   = 7;   // word address width, map spans 66 words
  localparam int QUAD_W   = REG_AW - 2;
  localparam int SUM_BASE = 64;  // first summary word address
  localparam int MAX_GROUPS = 64;

  typedef struct packed {
    logic              setEn;     // enable-set write hit
    logic              clrEn;     // enable-clear write hit
    logic              rdRaw;     // raw pending read
    logic              rdMasked;  // enabled pending read
    logic              rdSum;     // summary read
    logic              rdZero;    // read that returns zero
    logic              badWr;     // illegal write
    logic [QUAD_W-1:0] quad;      // addressed quad
    logic              sumIdx;    // which summary word
  } ctlStrobes_t;
endpackage

// File: rtl/irq_comb_ctrl.sv
module irq_comb_ctrl
  import irq_comb_pkg::*;
#(
  parameter int NUM_QUADS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [REG_AW-1:0] addr,
  output ctlStrobes_t       ctl,
  output logic              wrErr
);
  logic [QUAD_W-1:0] quadField;
  logic [1:0]        wordSel;
  logic              quadValid;
  logic              sumHit;
  logic              legalWr;

  assign quadField = addr[REG_AW-1:2];
  assign wordSel   = addr[1:0];
  assign quadValid = !addr[REG_AW-1] && (int'(quadField) < NUM_QUADS);
  assign sumHit    = (int'(addr) == SUM_BASE) || (int'(addr) == SUM_BASE + 1);
  assign legalWr   = quadValid && !wordSel[1];

  always_comb begin
    ctl          = '0;
    ctl.quad     = quadField;
    ctl.sumIdx   = addr[0];
    ctl.setEn    = wrEn && legalWr && (wordSel == 2'd0);
    ctl.clrEn    = wrEn && legalWr && (wordSel == 2'd1);
    ctl.badWr    = wrEn && !legalWr;
    ctl.rdRaw    = rdEn && quadValid && (wordSel == 2'd2);
    ctl.rdMasked = rdEn && quadValid && (wordSel == 2'd3);
    ctl.rdSum    = rdEn && sumHit;
    ctl.rdZero   = rdEn && !(ctl.rdRaw || ctl.rdMasked || ctl.rdSum);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrErr <= 1'b0;
    else       wrErr <= ctl.badWr;
  end

  // R9
  err_follows_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrErr |-> $past(wrEn));

  // R10
  one_read_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.rdRaw, ctl.rdMasked, ctl.rdSum, ctl.rdZero}));
endmodule

// File: rtl/irq_comb_group.sv
module irq_comb_group
  import irq_comb_pkg::*;
#(
  parameter bit GROUP_ON = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LANE_W-1:0] srcIn,
  input  logic [LANE_W-1:0] setBits,
  input  logic [LANE_W-1:0] clrBits,
  output logic [LANE_W-1:0] mask,
  output logic [LANE_W-1:0] pending,
  output logic              irqOut
);
  logic [LANE_W-1:0] srcLive;
  logic [LANE_W-1:0] maskNext;

  assign srcLive  = GROUP_ON ? srcIn : '0;
  assign maskNext = (mask | setBits) & ~clrBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mask    <= '0;
      pending <= '0;
      irqOut  <= 1'b0;
    end else begin
      mask    <= maskNext;
      pending <= srcLive;
      irqOut  <= |(maskNext & srcLive);
    end
  end

  // R2
  line_matches_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (|(mask & pending)));

  // R3
  set_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|setBits && clrBits == '0) |=> ((mask & $past(setBits)) == $past(setBits)));

  // R4
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|clrBits) |=> ((mask & $past(clrBits)) == '0));

  generate
    if (!GROUP_ON) begin : g_off
      // R11
      ignored_group_chk: assert property (@(posedge clk) disable iff (!rstN)
        pending == '0 && !irqOut);
    end
  endgenerate
endmodule

// File: rtl/irq_comb_datapath.sv
module irq_comb_datapath
  import irq_comb_pkg::*;
#(
  parameter int NUM_GROUPS    = 64,
  parameter int ACTIVE_GROUPS = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctlStrobes_t                  ctl,
  input  logic [WORD_W-1:0]            wdata,
  input  logic [NUM_GROUPS*LANE_W-1:0] srcIn,
  output logic [WORD_W-1:0]            rdata,
  output logic [NUM_GROUPS-1:0]        grpIrq
);
  localparam int GI_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

  logic [LANE_W-1:0] maskArr [NUM_GROUPS];
  logic [LANE_W-1:0] pendArr [NUM_GROUPS];
  logic [NUM_GROUPS*LANE_W-1:0] maskFlat;

  genvar g;
  generate
    for (g = 0; g < NUM_GROUPS; g++) begin : g_grp
      localparam int QIDX = g / LANES;
      localparam int LIDX = g % LANES;
      logic hit;
      logic [LANE_W-1:0] setBits;
      logic [LANE_W-1:0] clrBits;

      assign hit     = (int'(ctl.quad) == QIDX);
      assign setBits = (ctl.setEn && hit) ? wdata[LIDX*LANE_W +: LANE_W] : '0;
      assign clrBits = (ctl.clrEn && hit) ? wdata[LIDX*LANE_W +: LANE_W] : '0;
      assign maskFlat[g*LANE_W +: LANE_W] = maskArr[g];

      irq_comb_group #(
        .GROUP_ON(g < ACTIVE_GROUPS)
      ) u_grp (
        .clk    (clk),
        .rstN   (rstN),
        .srcIn  (srcIn[g*LANE_W +: LANE_W]),
        .setBits(setBits),
        .clrBits(clrBits),
        .mask   (maskArr[g]),
        .pending(pendArr[g]),
        .irqOut (grpIrq[g])
      );
    end
  endgenerate

  logic [WORD_W-1:0]      rawWord;
  logic [WORD_W-1:0]      mskWord;
  logic [MAX_GROUPS-1:0]  sumPad;
  logic [WORD_W-1:0]      sumWord;

  always_comb begin
    rawWord = '0;
    mskWord = '0;
    for (int k = 0; k < LANES; k++) begin
      int gi;
      gi = int'(ctl.quad) * LANES + k;
      if (gi < NUM_GROUPS) begin
        rawWord[k*LANE_W +: LANE_W] = pendArr[gi[GI_W-1:0]];
        mskWord[k*LANE_W +: LANE_W] = pendArr[gi[GI_W-1:0]] & maskArr[gi[GI_W-1:0]];
      end
    end
  end

  always_comb begin
    sumPad = '0;
    sumPad[NUM_GROUPS-1:0] = grpIrq;
  end

  assign sumWord = ctl.sumIdx ? sumPad[MAX_GROUPS-1:WORD_W] : sumPad[WORD_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdata <= '0;
    else if (ctl.rdRaw)    rdata <= rawWord;
    else if (ctl.rdMasked) rdata <= mskWord;
    else if (ctl.rdSum)    rdata <= sumWord;
    else if (ctl.rdZero)   rdata <= '0;
  end

  // R9
  bad_write_inert_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.badWr |=> $stable(maskFlat));

  // R10
  zero_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rdZero |=> rdata == '0);
endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner
  import irq_comb_pkg::*;
#(
  parameter int NUM_GROUPS    = 64,
  parameter int ACTIVE_GROUPS = NUM_GROUPS
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_GROUPS*LANE_W-1:0] srcIn,
  input  logic                         wrEn,
  input  logic                         rdEn,
  input  logic [REG_AW-1:0]            addr,
  input  logic [WORD_W-1:0]            wdata,
  output logic [WORD_W-1:0]            rdata,
  output logic                         wrErr,
  output logic [NUM_GROUPS-1:0]        grpIrq
);
  localparam int NUM_QUADS = NUM_GROUPS / LANES;

  ctlStrobes_t ctl;

  irq_comb_ctrl #(
    .NUM_QUADS(NUM_QUADS)
  ) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .ctl  (ctl),
    .wrErr(wrErr)
  );

  irq_comb_datapath #(
    .NUM_GROUPS   (NUM_GROUPS),
    .ACTIVE_GROUPS(ACTIVE_GROUPS)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .wdata (wdata),
    .srcIn (srcIn),
    .rdata (rdata),
    .grpIrq(grpIrq)
  );
endmodule

// File: tb/tb_irq_group_combiner.sv
module tb_irq_group_combiner;
  localparam int NG = 8;
  localparam int AG = 6;
  localparam int NQ = NG / 4;
  localparam int NS = NG * 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] srcIn = '0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [6:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          wrErr;
  logic [NG-1:0] grpIrq;

  irq_group_combiner #(.NUM_GROUPS(NG), .ACTIVE_GROUPS(AG)) dut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wdata(wdata), .rdata(rdata), .wrErr(wrErr), .grpIrq(grpIrq)
  );

  always #5 clk = ~clk;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t rdQ[$];

  logic [7:0] maskM [NG];
  logic       rdSeen = 1'b0;

  always @(posedge clk) rdSeen <= rdEn;

  // monitor: pops one expectation per completed read
  always @(negedge clk) begin
    item_t it;
    if (rdSeen) begin
      checks++;
      if (rdQ.size() == 0) begin
        fails++;
        $display("FAIL R10: read result with no expectation, actual %h expected none", rdata);
      end else begin
        it = rdQ.pop_front();
        if (rdata !== it.exp) begin
          fails++;
          $display("FAIL %s: rdata actual %h expected %h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  function automatic logic [7:0] liveSrc(int g);
    return (g < AG) ? srcIn[g*8 +: 8] : 8'h00;
  endfunction

  function automatic logic [NG-1:0] expIrq();
    logic [NG-1:0] v;
    for (int g = 0; g < NG; g++) v[g] = |(maskM[g] & liveSrc(g));
    return v;
  endfunction

  function automatic logic [31:0] expRaw(int q);
    logic [31:0] v = '0;
    for (int k = 0; k < 4; k++) v[k*8 +: 8] = liveSrc(q*4 + k);
    return v;
  endfunction

  function automatic logic [31:0] expMasked(int q);
    logic [31:0] v = '0;
    for (int k = 0; k < 4; k++) v[k*8 +: 8] = liveSrc(q*4 + k) & maskM[q*4 + k];
    return v;
  endfunction

  function automatic logic [31:0] expSum(int w);
    logic [63:0] p = '0;
    p[NG-1:0] = expIrq();
    return w ? p[63:32] : p[31:0];
  endfunction

  task automatic checkIrq(string tag);
    checks++;
    if (grpIrq !== expIrq()) begin
      fails++;
      $display("FAIL %s: grpIrq actual %b expected %b", tag, grpIrq, expIrq());
    end
  endtask

  task automatic checkErr(logic exp, string tag);
    checks++;
    if (wrErr !== exp) begin
      fails++;
      $display("FAIL %s: wrErr actual %b expected %b", tag, wrErr, exp);
    end
  endtask

  // driver: one register write, model updated, error pulse checked
  task automatic regWrite(int a, logic [31:0] d);
    bit legal;
    legal = (a < 64) && ((a % 4) < 2) && ((a / 4) < NQ);
    @(negedge clk);
    wrEn = 1'b1; addr = 7'(a); wdata = d;
    if (legal) begin
      for (int k = 0; k < 4; k++) begin
        if (a % 4 == 0) maskM[(a/4)*4 + k] = maskM[(a/4)*4 + k] | d[k*8 +: 8];
        else            maskM[(a/4)*4 + k] = maskM[(a/4)*4 + k] & ~d[k*8 +: 8];
      end
    end
    @(negedge clk);
    wrEn = 1'b0;
    checkErr(!legal, "R9");
  endtask

  // driver: one register read, expectation pushed for the monitor
  task automatic regRead(int a, logic [31:0] e, string tag);
    item_t it;
    @(negedge clk);
    rdEn = 1'b1; addr = 7'(a);
    it.exp = e; it.tag = tag;
    rdQ.push_back(it);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic setSrc(logic [NS-1:0] v);
    @(negedge clk);
    srcIn = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R8: watchdog expired, actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < NG; g++) maskM[g] = 8'h00;
    repeat (3) @(negedge clk);
    checkIrq("R8");
    checkErr(1'b0, "R8");
    rstN = 1'b1;
    regRead(2, 32'h0, "R8");
    regRead(64, 32'h0, "R8");

    // source 13 -> group 1 bit 5, lane 1 of quad 0
    setSrc(NS'(1) << 13);
    checkIrq("R1");
    regRead(2, expRaw(0), "R1");
    regRead(3, expMasked(0), "R6");

    regWrite(0, 32'h0000_2000);
    checkIrq("R12");
    regRead(3, expMasked(0), "R6");
    regRead(64, expSum(0), "R7");

    regWrite(0, 32'h0);
    regRead(3, expMasked(0), "R3");
    regWrite(1, 32'h0);
    checkIrq("R4");
    regWrite(1, 32'h0000_2000);
    checkIrq("R4");
    regRead(3, expMasked(0), "R4");

    regWrite(0, 32'h0000_2000);
    checkIrq("R3");
    setSrc('0);
    checkIrq("R2");
    regRead(2, expRaw(0), "R1");

    // second quad, ignored groups 6 and 7
    setSrc((NS'(1) << 40) | (NS'(1) << 33) | (NS'(16'hFFFF) << 48));
    regWrite(4, 32'hFFFF_FFFF);
    checkIrq("R11");
    regRead(6, expRaw(1), "R11");
    regRead(7, expMasked(1), "R6");
    regRead(64, expSum(0), "R7");
    regRead(65, expSum(1), "R7");
    regRead(2, expRaw(0), "R5");

    // illegal writes
    regWrite(2, 32'hFFFF_FFFF);
    regRead(3, expMasked(0), "R9");
    regWrite(7, 32'h0);
    regWrite(64, 32'hFF);
    regWrite(65, 32'hFF);
    regWrite(8, 32'hFFFF_FFFF);
    @(negedge clk);
    checkErr(1'b0, "R9");
    regWrite(100, 32'hFFFF_FFFF);
    regRead(7, expMasked(1), "R9");
    regRead(3, expMasked(0), "R9");
    checkIrq("R9");

    // zero reads
    regRead(0, 32'h0, "R10");
    regRead(1, 32'h0, "R10");
    regRead(5, 32'h0, "R10");
    regRead(40, 32'h0, "R10");

    // drop group 4 source
    setSrc(srcIn & ~(NS'(1) << 33));
    checkIrq("R2");
    regRead(64, expSum(0), "R7");

    // reset in the middle of the run
    @(negedge clk);
    rstN = 1'b0;
    for (int g = 0; g < NG; g++) maskM[g] = 8'h00;
    @(negedge clk);
    checkIrq("R8");
    rstN = 1'b1;
    @(negedge clk);
    checkIrq("R8");
    regRead(7, expMasked(1), "R8");
    regRead(6, expRaw(1), "R1");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule